// File: doc/BRIEF.md
# Late-Capture-Detecting Multiply-Accumulate Register

This block is the accumulation stage of a multiply-accumulate unit that is meant to run at a supply voltage too low to guarantee timing on every path. Each cycle, a product arrives on a valid/ready stream. When the stream transfers, the product is sign-extended and added to a wide accumulator. The sum wraps modulo two to the accumulator width. Only the most significant slice of the accumulator register is exposed to slow paths, so only that slice is protected.

Each protected bit has a main flop, clocked on the rising edge, and a shadow flop on the same data line, clocked on the falling edge. The clock duty cycle sets how late the data may arrive. When the two copies of any protected bit disagree, a falling-edge error flag rises. On the next rising edge the main flops reload the shadow value and the lower bits hold. That cycle is a recovery bubble: the stream is not accepted, the event is counted in a saturating counter, and a voltage-control agent can read the counter. An injection mask makes chosen protected main flops keep their old value on a capture, which imitates a late-arriving result. The mask serves verification.

The stream rule is simple. A product transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops only for a recovery bubble, and a producer holding `in_valid` keeps its product until it is taken.

Top module: `razor_mac_acc`

## Requirements
- R1: On each rising edge where `in_valid` and `in_ready` are high and `clr` is low, the accumulator becomes its old value plus `in_product` read as two's complement and sign-extended. The result wraps modulo 2^ACC_W.
- R2: `clr` high at a rising edge loads zero into the whole accumulator. It takes priority over accumulation, injection and recovery.
- R3: Injection affects only the upper PROT_W accumulator bits. A bit set in `inj_mask` (bit i maps to accumulator bit ACC_W-PROT_W+i) makes that main bit keep its previous value on that capture. The lower ACC_W-PROT_W bits always take the correct sum.
- R4: After a capture whose upper main bits differ from the value on the data line, `stall_o` rises at the next falling edge and falls at the falling edge after that. `in_ready` is always the complement of `stall_o`.
- R5: At the rising edge where `stall_o` is high (and `clr` low), the upper bits reload the correct value from the shadow flops, the lower bits hold, and the stream input is not taken.
- R6: `err_o` is high for exactly the one cycle that follows each recovery edge.
- R7: `err_cnt_o` adds one for each recovery edge, including one where `clr` is high. It stops at its all-ones value.
- R8: No stall occurs when the mask is zero, or when the masked bits would not have changed. A mask applied on a recovery edge has no effect.
- R9: After reset the accumulator, `err_o`, `stall_o` and `err_cnt_o` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Main flops use the rising edge, shadow and error flops the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Product stream valid |
| in_ready | output | 1 | Product stream ready, low during a recovery bubble |
| in_product | input | PROD_W | Two's-complement product |
| clr | input | 1 | Synchronous accumulator clear |
| inj_mask | input | PROT_W | Verification hook: protected main bits that capture stale |
| acc_o | output | ACC_W | Accumulator value |
| err_o | output | 1 | One-cycle pulse after a recovery |
| stall_o | output | 1 | Recovery in progress |
| err_cnt_o | output | CNT_W | Saturating count of detected errors |

## Verification
The bench builds the block with a 12-bit accumulator, a 4-bit protected slice, 6-bit products and a 3-bit error counter. At these widths every product value and every injection mask can be combined across a long run with idle gaps. The small accumulator wraps often, so carries into the protected slice are frequent and most non-zero masks produce real errors. The 3-bit counter reaches its saturation point within the run. Directed steps also cover a clear and a mask that land on a recovery edge.

// File: rtl/razor_mac_pkg.sv
`timescale 1ns/1ps
package razor_mac_pkg;
  typedef enum logic {
    PH_RUN     = 1'b0,
    PH_RECOVER = 1'b1
  } rmac_phase_e;
endpackage

// File: rtl/rmac_adder.sv
`timescale 1ns/1ps
module rmac_adder #(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              add_i,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] ext;

  // Sign-extend the product to the accumulator width.
  assign ext   = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};
  // The add wraps modulo 2^ACC_W.
  assign sum_o = add_i ? (acc_i + ext) : acc_i;
endmodule

// File: rtl/rmac_razor_bank.sv
`timescale 1ns/1ps
module rmac_razor_bank #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] inj_i,
  input  logic         restore_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic         err_o
);
  logic [W-1:0] shd_vec;
  logic [W-1:0] eb_vec;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic main_q;
    logic line_q;
    logic shd_q;
    logic eb_q;

    // Main flop, rising edge. Priority: clear, then restore from shadow,
    // then a stale hold when this bit is injected, else the sum bit.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         main_q <= 1'b0;
      else if (clr_i)     main_q <= 1'b0;
      else if (restore_i) main_q <= shd_q;
      else if (inj_i[b])  main_q <= main_q;
      else                main_q <= d_i[b];
    end

    // Models the value the data line settles to after the rising edge.
    // It always carries the correct result.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         line_q <= 1'b0;
      else if (clr_i)     line_q <= 1'b0;
      else if (restore_i) line_q <= shd_q;
      else                line_q <= d_i[b];
    end

    // Shadow flop and per-bit compare, falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= 1'b0;
        eb_q  <= 1'b0;
      end else begin
        shd_q <= line_q;
        eb_q  <= line_q ^ main_q;
      end
    end

    assign q_o[b]     = main_q;
    assign shd_vec[b] = shd_q;
    assign eb_vec[b]  = eb_q;
  end

  assign err_o = |eb_vec;

  AST_RESTORE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !clr_i) |=> (q_o == $past(shd_vec))); // R5
  AST_CLEAR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_o == '0)); // R2
endmodule

// File: rtl/rmac_err_counter.sv
`timescale 1ns/1ps
module rmac_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/razor_mac_acc.sv
`timescale 1ns/1ps
module razor_mac_acc
  import razor_mac_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int PROT_W = 10,
  parameter int PROD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PROD_W-1:0] in_product,
  input  logic              clr,
  input  logic [PROT_W-1:0] inj_mask,
  output logic [ACC_W-1:0]  acc_o,
  output logic              err_o,
  output logic              stall_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int LO_W = ACC_W - PROT_W;

  logic [LO_W-1:0]   lo_q;
  logic [PROT_W-1:0] hi_q;
  logic [ACC_W-1:0]  acc_cur;
  logic [ACC_W-1:0]  sum;
  logic              err_n;
  logic              fire;
  logic              restore;
  logic              err_pulse_q;
  rmac_phase_e       phase;

  assign phase    = err_n ? PH_RECOVER : PH_RUN;
  assign stall_o  = (phase == PH_RECOVER);
  assign in_ready = !stall_o;
  assign fire     = in_valid && in_ready;
  assign restore  = stall_o && !clr;
  assign acc_cur  = {hi_q, lo_q};
  assign acc_o    = acc_cur;

  rmac_adder #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_add (
    .acc_i  (acc_cur),
    .prod_i (in_product),
    .add_i  (fire),
    .sum_o  (sum)
  );

  // Lower slice: plain flops, hold during a recovery bubble.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_q <= '0;
    else if (clr)      lo_q <= '0;
    else if (!stall_o) lo_q <= sum[LO_W-1:0];
  end

  rmac_razor_bank #(.W(PROT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_i       (sum[ACC_W-1:LO_W]),
    .inj_i     (inj_mask),
    .restore_i (restore),
    .clr_i     (clr),
    .q_o       (hi_q),
    .err_o     (err_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse_q <= 1'b0;
    else        err_pulse_q <= err_n;
  end
  assign err_o = err_pulse_q;

  rmac_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (err_n),
    .cnt_o (err_cnt_o)
  );

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_o == '0)); // R2
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !clr) |=> (lo_q == $past(lo_q))); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && err_cnt_o != {CNT_W{1'b1}}) |=> (err_cnt_o == $past(err_cnt_o) + 1'b1)); // R7
endmodule

// File: tb/razor_mac_acc_tb.sv
`timescale 1ns/1ps
module razor_mac_acc_tb;
  localparam int ACC_W  = 12;
  localparam int PROT_W = 4;
  localparam int PROD_W = 6;
  localparam int CNT_W  = 3;
  localparam int LO_W   = ACC_W - PROT_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [PROD_W-1:0] in_product = '0;
  logic              clr = 1'b0;
  logic [PROT_W-1:0] inj_mask = '0;
  logic [ACC_W-1:0]  acc_o;
  logic              err_o;
  logic              stall_o;
  logic [CNT_W-1:0]  err_cnt_o;

  int tests = 0;
  int fails = 0;
  logic [ACC_W-1:0] ref_acc = '0;
  logic             pend = 1'b0;
  int               cnt_ref = 0;

  always #5 clk = ~clk;

  razor_mac_acc #(.ACC_W(ACC_W), .PROT_W(PROT_W), .PROD_W(PROD_W), .CNT_W(CNT_W)) u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_product, .clr, .inj_mask,
    .acc_o, .err_o, .stall_o, .err_cnt_o
  );

  function automatic logic [ACC_W-1:0] sext(input logic [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs are driven just after a rising edge; stall is checked after the
  // falling edge and outputs after the next rising edge.
  task automatic do_cycle(input logic v, input logic [PROD_W-1:0] p,
                          input logic [PROT_W-1:0] m, input logic c);
    logic [ACC_W-1:0] nxt;
    logic [ACC_W-1:0] shown;
    logic             was_pend;
    in_valid = v; in_product = p; inj_mask = m; clr = c;
    @(negedge clk); #1;
    check(stall_o == pend, "R4 stall", stall_o, pend);
    check(in_ready == !pend, "R4 ready", in_ready, !pend);
    was_pend = pend;
    @(posedge clk); #1;
    if (c) begin
      ref_acc = '0; shown = '0; pend = 1'b0;           // R2
    end else if (was_pend) begin
      shown = ref_acc; pend = 1'b0;                     // R5, mask ignored (R8)
    end else begin
      nxt = v ? ref_acc + sext(p) : ref_acc;            // R1
      shown = nxt;
      shown[ACC_W-1:LO_W] = (nxt[ACC_W-1:LO_W] & ~m) | (ref_acc[ACC_W-1:LO_W] & m); // R3
      pend = (((nxt ^ ref_acc) >> LO_W) & ACC_W'(m)) != 0; // R8
      ref_acc = nxt;
    end
    if (was_pend && cnt_ref < CMAX) cnt_ref++;
    check(acc_o == shown, "R1/R3/R5 acc", acc_o, shown);
    check(err_o == was_pend, "R6 err", err_o, was_pend);
    check(err_cnt_o == CNT_W'(cnt_ref), "R7 count", err_cnt_o, cnt_ref);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(acc_o == 0, "R9 acc", acc_o, 0);
    check(err_cnt_o == 0 && !err_o && !stall_o && in_ready, "R9 flags", err_cnt_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // Directed: adding -1 to zero flips every upper bit; stale capture.
    do_cycle(1'b1, '1, '1, 1'b0);
    // Clear lands on the recovery edge.
    do_cycle(1'b1, 6'd5, '0, 1'b1);
    // Another error, then a mask on the recovery edge is ignored.
    do_cycle(1'b1, '1, 4'b0101, 1'b0);
    do_cycle(1'b1, 6'd3, '1, 1'b0);
    do_cycle(1'b0, '0, '1, 1'b0);
    do_cycle(1'b1, 6'd1, '1, 1'b0);
    // Sweep: every product, every mask, with idle gaps and clears.
    for (int i = 0; i < 1600; i++) begin
      do_cycle((i % 7) != 5, PROD_W'(i), (i % 3 == 0) ? PROT_W'(i / 3) : '0,
               (i % 400) == 399);
    end
    do_cycle(1'b0, '0, '0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule